// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer

This block holds three independent down-counters, each with its own reload value and control word, behind a small register bus. A single run register holds one enable bit per channel. While a channel is enabled, its counter steps down once per tick. The tick comes from one of several sources: a channel-local prescaler on the core clock, a real-time-clock tick pulse, or an external clock pin.

When a running counter at zero receives a tick, it underflows. The counter takes the reload value, and the channel's underflow flag sets. Software can clear the flag but can never set it. Each channel drives its own interrupt line, which is high whenever both the flag and the channel's interrupt enable are set.

The bus is single-cycle. A write happens on the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`.

Top module: `tri_timer`

## Requirements
- R1: After reset, every counter and control word reads 0, every reload value reads 0xFFFFFFFF, the run register reads 0 and all interrupt lines are low.
- R2: Run register bit i (byte address 0x00) enables channel i when 1. When it is 0 the channel's counter holds its value, and counting resumes from that value when the bit is set again.
- R3: Channel i occupies byte addresses 0x04+12*i (counter), 0x08+12*i (reload) and 0x0C+12*i (control). In the control word, bits [2:0] select the tick source, bit 5 is the interrupt enable and bit 8 is the underflow flag. Every other control bit, including bit 9, reads 0.
- R4: Source codes 0, 1, 2, 3, 4 and 5 divide the core clock by 4, 16, 64, 256, 1024 and 4096. After a counter write, the first decrement lands exactly one division period later.
- R5: Source code 6 decrements the counter once for each clock cycle in which `rtc_tick` is high.
- R6: Source code 7 decrements the counter once per rising edge of `ext_clk`, after that pin passes through a two-flop synchronizer.
- R7: From counter value V, the (V+1)-th tick loads the reload value into the counter and sets the underflow flag.
- R8: Writing 0 to control bit 8 clears the flag. Writing 1 keeps the flag's current value, so software can never set it.
- R9: `irq[i]` is high exactly when channel i's flag and its enable are both set. It follows a control write on the next cycle.
- R10: Writing a running channel's counter restarts that channel's prescaler phase from the cycle of the write.
- R11: Ticks, writes and underflows on one channel leave the other channels' counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data for `bus_addr` |
| rtc_tick | input | 1 | Real-time-clock tick, one cycle per tick |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq | output | NCH (3) | Per-channel underflow interrupt |

## Verification
The bench builds the block with its default parameters: three channels, 32-bit counters and a 12-bit prescaler phase counter. With a 12-bit phase counter every divider, including divide-by-4096, completes a full period within a short run, so the first-decrement timing of R4 is checked at the exact cycle for all six codes. The 32-bit width lets the bench observe the all-ones reload reset value directly. Three channels are enough to run the RTC and external sources on separate channels while watching a stopped neighbour for R11.

// File: rtl/tri_timer.sv
`timescale 1ns/1ps
module tri_timer #(
  parameter int NCH = 3,
  parameter int CW  = 32,
  parameter int AW  = 8,
  parameter int PW  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [CW-1:0]       bus_wdata,
  output logic [CW-1:0]       bus_rdata,
  input  logic                rtc_tick,
  input  logic                ext_clk,
  output logic [NCH-1:0]      irq
);
  localparam int BASE   = 4;
  localparam int STRIDE = 12;

  logic [NCH-1:0]         run;
  logic [NCH-1:0][CW-1:0] cnt, rld;
  logic [NCH-1:0][2:0]    src;
  logic [NCH-1:0]         ie, flag;
  logic [NCH-1:0][PW-1:0] pc;
  logic [2:0]             ext_s;
  logic [NCH-1:0]         tick, uf, wc, wl, wt;

  wire ext_tick = ext_s[1] & ~ext_s[2];
  wire wr_run   = bus_wr && bus_addr == '0;

  function automatic logic pre_hit(input logic [PW-1:0] p, input logic [2:0] code);
    int sh;
    logic [PW-1:0] m;
    sh = (code == 3'd5) ? 12 : 2 * (int'(code) + 1);
    m  = PW'((64'd1 << sh) - 64'd1);
    return (p & m) == m;
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      wc[i] = bus_wr && bus_addr == AW'(BASE + STRIDE*i);
      wl[i] = bus_wr && bus_addr == AW'(BASE + STRIDE*i + 4);
      wt[i] = bus_wr && bus_addr == AW'(BASE + STRIDE*i + 8);
      case (src[i])
        3'd6:    tick[i] = run[i] & rtc_tick;
        3'd7:    tick[i] = run[i] & ext_tick;
        default: tick[i] = run[i] & pre_hit(pc[i], src[i]);
      endcase
      uf[i] = tick[i] && cnt[i] == '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= '0;
      ext_s <= '0;
      for (int i = 0; i < NCH; i++) begin
        cnt[i]  <= '0;
        rld[i]  <= '1;
        src[i]  <= '0;
        ie[i]   <= 1'b0;
        flag[i] <= 1'b0;
        pc[i]   <= '0;
      end
    end else begin
      ext_s <= {ext_s[1:0], ext_clk};
      if (wr_run) run <= bus_wdata[NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (wc[i])        cnt[i] <= bus_wdata;
        else if (tick[i]) cnt[i] <= uf[i] ? rld[i] : cnt[i] - 1'b1;
        if (wc[i] || (wr_run && bus_wdata[i] && !run[i])) pc[i] <= '0;
        else if (run[i])  pc[i] <= pc[i] + 1'b1;
        if (wl[i]) rld[i] <= bus_wdata;
        if (wt[i]) begin
          src[i] <= bus_wdata[2:0];
          ie[i]  <= bus_wdata[5];
        end
        flag[i] <= uf[i] | (flag[i] & ~(wt[i] & ~bus_wdata[8]));
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = CW'(run);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(BASE + STRIDE*i))     bus_rdata = cnt[i];
      if (bus_addr == AW'(BASE + STRIDE*i + 4)) bus_rdata = rld[i];
      if (bus_addr == AW'(BASE + STRIDE*i + 8))
        bus_rdata = CW'({flag[i], 2'b00, ie[i], 2'b00, src[i]});
    end
  end

  assign irq = flag & ie;
endmodule

// File: rtl/tri_timer_chk.sv
`timescale 1ns/1ps
module tri_timer_chk #(
  parameter int NCH = 3,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [CW-1:0]          bus_wdata,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0][CW-1:0] rld,
  input logic [NCH-1:0]         flag
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire wc = bus_wr && bus_addr == AW'(4 + 12*i);
    wire wt = bus_wr && bus_addr == AW'(4 + 12*i + 8);

    p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !wc) |=> $stable(cnt[i]));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && !wc && cnt[i] != '0) |=>
        (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) - 1'b1));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wc && cnt[i] == '0) |=> (cnt[i] == '0 || cnt[i] == $past(rld[i])));

    p_no_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wt && !run[i] && !flag[i]) |=> !flag[i]);

    p_irq_en_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wt && !bus_wdata[5]) |=> !irq[i]);

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wt && !bus_wdata[8] && !run[i]) |=> !irq[i]);
  end
endmodule

bind tri_timer tri_timer_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .run(run), .cnt(cnt), .rld(rld),
  .flag(flag)
);

// File: tb/sim_tri_timer.sv
`timescale 1ns/1ps
module sim_tri_timer;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rtc_tick = 1'b0, ext_clk = 1'b0;
  logic [2:0]  irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tri_timer u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick),
    .ext_clk(ext_clk), .irq(irq));

  function automatic logic [7:0] a_cnt(int ch); return 8'(4 + 12*ch); endfunction
  function automatic logic [7:0] a_rld(int ch); return 8'(8 + 12*ch); endfunction
  function automatic logic [7:0] a_ctl(int ch); return 8'(12 + 12*ch); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 run", v, 0);
    for (int c = 0; c < 3; c++) begin
      rd(a_cnt(c), v); check("R1 cnt", v, 0);
      rd(a_rld(c), v); check("R1 rld", v, 32'hFFFF_FFFF);
      rd(a_ctl(c), v); check("R1 ctl", v, 0);
    end
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_dividers;
    logic [31:0] v;
    for (int code = 0; code < 6; code++) begin
      int d = (code == 5) ? 4096 : (4 << (2*code));
      wr(a_ctl(0), 32'(code));
      wr(8'h00, 1);
      wr(a_cnt(0), 100);
      repeat (d-1) @(posedge clk);
      #1; rd(a_cnt(0), v); check("R4 before period", v, 100);
      @(posedge clk); #1; rd(a_cnt(0), v); check("R4 first step", v, 99);
      wr(8'h00, 0);
    end
  endtask

  task automatic t_underflow;
    logic [31:0] v;
    wr(a_ctl(0), 32'h20);
    wr(a_rld(0), 5);
    wr(8'h00, 1);
    wr(a_cnt(0), 2);
    repeat (11) @(posedge clk);
    #1; rd(a_cnt(0), v); check("R7 at zero", v, 0);
    rd(a_ctl(0), v); check("R7 flag not yet", 32'(v[8]), 0);
    check("R9 irq low", 32'(irq[0]), 0);
    @(posedge clk); #1; rd(a_cnt(0), v); check("R7 reload", v, 5);
    rd(a_ctl(0), v); check("R7 flag set", 32'(v[8]), 1);
    check("R9 irq high", 32'(irq[0]), 1);
    wr(8'h00, 0);
    wr(a_ctl(0), 32'h120);
    rd(a_ctl(0), v); check("R8 keep on 1", 32'(v[8]), 1);
    check("R9 irq kept", 32'(irq[0]), 1);
    wr(a_ctl(0), 32'h20);
    rd(a_ctl(0), v); check("R8 clear on 0", 32'(v[8]), 0);
    check("R9 irq drop", 32'(irq[0]), 0);
    wr(a_ctl(0), 32'h120);
    rd(a_ctl(0), v); check("R8 no sw set", 32'(v[8]), 0);
    check("R8 irq stays low", 32'(irq[0]), 0);
    wr(a_ctl(0), 32'h0);
    wr(8'h00, 1);
    wr(a_cnt(0), 0);
    repeat (6) @(posedge clk);
    #1; rd(a_ctl(0), v); check("R7 flag w/o enable", 32'(v[8]), 1);
    check("R9 masked", 32'(irq[0]), 0);
    wr(a_ctl(0), 32'h120);
    check("R9 enable raises irq", 32'(irq[0]), 1);
    wr(8'h00, 0);
    wr(a_ctl(0), 32'h0);
    check("R9 off after clear", 32'(irq[0]), 0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(a_ctl(0), 2);
    wr(8'h00, 1);
    wr(a_cnt(0), 10);
    repeat (40) @(posedge clk);
    wr(a_cnt(0), 10);
    repeat (63) @(posedge clk);
    #1; rd(a_cnt(0), v); check("R10 phase restarted", v, 10);
    @(posedge clk); #1; rd(a_cnt(0), v); check("R10 step after 64", v, 9);
    wr(8'h00, 0);
  endtask

  task automatic t_freeze;
    logic [31:0] a, b;
    wr(a_ctl(0), 0);
    wr(8'h00, 1);
    wr(a_cnt(0), 1000);
    repeat (20) @(posedge clk);
    wr(8'h00, 0);
    rd(a_cnt(0), a);
    check("R2 counted", 32'(a < 1000), 1);
    repeat (30) @(posedge clk);
    #1; rd(a_cnt(0), b); check("R2 frozen", b, a);
    wr(8'h00, 1);
    repeat (40) @(posedge clk);
    wr(8'h00, 0);
    rd(a_cnt(0), b); check("R2 resumed", 32'(b < a && b > a - 20), 1);
  endtask

  task automatic t_rtc;
    logic [31:0] v, c0;
    rd(a_cnt(0), c0);
    wr(a_ctl(1), 6);
    wr(8'h00, 2);
    wr(a_cnt(1), 100);
    repeat (10) @(posedge clk);
    #1; rd(a_cnt(1), v); check("R5 idle", v, 100);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rtc_tick = 1'b1;
      @(negedge clk); rtc_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
    rd(a_cnt(1), v); check("R5 three pulses", v, 97);
    rd(a_cnt(0), v); check("R11 ch0 untouched", v, c0);
  endtask

  task automatic t_ext;
    logic [31:0] v;
    wr(a_ctl(2), 7);
    wr(8'h00, 6);
    wr(a_cnt(2), 50);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (3) @(negedge clk); ext_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd(a_cnt(2), v); check("R6 four edges", v, 46);
    rd(a_cnt(1), v); check("R11 ch1 untouched", v, 97);
    wr(8'h00, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(a_rld(2), 32'h1234_5678);
    rd(a_rld(2), v); check("R3 reload readback", v, 32'h1234_5678);
    rd(a_rld(1), v); check("R3 neighbour reload", v, 32'hFFFF_FFFF);
    wr(a_ctl(2), 32'hFFFF_FFFF);
    rd(a_ctl(2), v); check("R3 ctl bits", v, 32'h27);
    wr(8'h00, 32'h2);
    rd(8'h00, v); check("R3 run readback", v, 2);
    wr(8'h00, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_dividers();
    t_underflow();
    t_restart();
    t_freeze();
    t_rtc();
    t_ext();
    t_map();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule